// File: doc/BRIEF.md
# Burst SRAM Command and Byte-Write Decoder

This block sits between a memory controller and a synchronous burst SRAM core. On every rising clock edge it samples three chip enables, two address strobes (one from a processor, one from a cache controller), an advance input, a global write, a byte-write enable and one write enable per byte lane. From these it classifies the cycle and reports the class on its outputs. It also tells a downstream burst address counter whether to load the external address, step to the next address or keep the current one, and it produces the per-lane write enables for the cycle.

The processor strobe is masked by the first chip enable. The second and third chip enables matter only while a strobe is being acted on. A processor-strobe cycle always starts a read burst. Writes are started by the controller strobe or by continuation cycles. A five-state burst tracker (deselected, first read, first write, burst read, burst write) remembers whether a burst is open. The lane mask and the last loaded external address are registered so that the array write uses values captured in the same edge.

Top module: `burst_sram_cmd_dec`

## Requirements
- R1: With `gwr_n` low, every lane enable of a write-class cycle is 1, whatever `bwr_n` and `lane_n` are.
- R2: With `gwr_n` high and `bwr_n` low, exactly the lanes whose `lane_n` bit is 0 are enabled. If no `lane_n` bit is 0, the cycle is a read.
- R3: With `gwr_n` high and `bwr_n` high, the cycle is a read and `lane_we_o` is all zero.
- R4: While `ce1_n` is high, a low `cpu_stb_n` is ignored. The cycle behaves as if that strobe were high.
- R5: A cycle with an acting processor strobe and the chip selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0) is a begin-read (kind 1) with address select EXT (1). This holds even if the write controls request a write or the controller strobe is also low. `lane_we_o` is zero.
- R6: A controller-strobe cycle with the chip selected and no acting processor strobe is begin-write (kind 2) if any lane is enabled, otherwise begin-read (kind 1). Either way the address select is EXT (1).
- R7: A cycle with any acting strobe while the chip is not selected is deselect (kind 0). The address select is NONE (0) and `lane_we_o` is 0.
- R8: With no acting strobe and a burst open, a low `adv_n` gives continue (kind 3 read / 4 write, address select NEXT=2). A high `adv_n` gives suspend (kind 5 read / 6 write, address select CUR=3). `ce2` and `ce3_n` have no effect in these cycles.
- R9: With no acting strobe in the deselected state, the cycle is deselect (kind 0) with address select NONE (0), and the state stays deselected.
- R10: `state_o` takes its next value on the rising edge. Deselect cycles lead to 0, begin-read to 1, begin-write to 2, continue/suspend reads to 3 and continue/suspend writes to 4.
- R11: After each rising edge, `wr_mask_q_o` equals the `lane_we_o` of the cycle just sampled. `load_addr_q_o` holds the external address of the most recent EXT cycle.
- R12: An active-low asynchronous reset forces `state_o` to 0, `wr_mask_q_o` to 0 and `load_addr_q_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce1_n | input | 1 | First chip enable, active low, masks processor strobe |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | External address |
| kind_o | output | 3 | Cycle class: 0 deselect, 1 begin read, 2 begin write, 3 continue read, 4 continue write, 5 suspend read, 6 suspend write |
| asel_o | output | 2 | Address select: 0 none, 1 external, 2 next, 3 current |
| lane_we_o | output | LANES | Lane write enables for this cycle |
| state_o | output | 3 | Burst state: 0 deselected, 1 first read, 2 first write, 3 burst read, 4 burst write |
| wr_mask_q_o | output | LANES | Lane mask registered at the last edge |
| load_addr_q_o | output | ADDR_W | Last loaded external address |

## Verification
A wrong burst state shows up one cycle later at `kind_o` and `asel_o`. A strobe-free cycle either stays deselected when a burst should continue, or reports continue/suspend when it should stay idle. A stale registered mask or address shows on `wr_mask_q_o` or `load_addr_q_o` right after the edge that should have updated it. The stimulus sequence moves through every state and both strobe priorities, so a corrupted state is seen within one or two cycles.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    typedef enum logic [2:0] {
        K_DESEL   = 3'd0,
        K_BEG_RD  = 3'd1,
        K_BEG_WR  = 3'd2,
        K_CONT_RD = 3'd3,
        K_CONT_WR = 3'd4,
        K_SUSP_RD = 3'd5,
        K_SUSP_WR = 3'd6
    } kind_e;

    typedef enum logic [1:0] {
        AS_NONE = 2'd0,
        AS_EXT  = 2'd1,
        AS_NEXT = 2'd2,
        AS_CUR  = 2'd3
    } asel_e;

    typedef enum logic [2:0] {
        S_DESEL = 3'd0,
        S_F_RD  = 3'd1,
        S_F_WR  = 3'd2,
        S_B_RD  = 3'd3,
        S_B_WR  = 3'd4
    } bst_e;

    function automatic logic kind_is_write(kind_e k);
        return (k == K_BEG_WR) || (k == K_CONT_WR) || (k == K_SUSP_WR);
    endfunction

endpackage

// File: rtl/bsd_lane_decode.sv
module bsd_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] mask_o,
    output logic             is_wr_o
);
    // Each lane is enabled by the global write, or by byte-write plus its own enable.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask_o[g] = ~gwr_n | (~bwr_n & ~lane_n[g]);
    end

    assign is_wr_o = |mask_o;
endmodule

// File: rtl/bsd_classify.sv
module bsd_classify
    import bsd_pkg::*;
(
    input  logic  ce1_n,
    input  logic  ce2,
    input  logic  ce3_n,
    input  logic  cpu_stb_n,
    input  logic  ctl_stb_n,
    input  logic  adv_n,
    input  logic  is_wr,
    input  bst_e  cur_st,
    output kind_e kind_o,
    output asel_e asel_o,
    output bst_e  nxt_st_o
);
    logic cpu_act;
    logic any_stb;
    logic sel;

    always_comb begin
        cpu_act  = ~cpu_stb_n & ~ce1_n;   // first enable masks the processor strobe
        any_stb  = cpu_act | ~ctl_stb_n;
        sel      = ~ce1_n & ce2 & ~ce3_n;
        kind_o   = K_DESEL;
        asel_o   = AS_NONE;
        nxt_st_o = S_DESEL;
        if (any_stb) begin
            if (!sel) begin
                kind_o   = K_DESEL;
                asel_o   = AS_NONE;
                nxt_st_o = S_DESEL;
            end else if (cpu_act || !is_wr) begin
                kind_o   = K_BEG_RD;
                asel_o   = AS_EXT;
                nxt_st_o = S_F_RD;
            end else begin
                kind_o   = K_BEG_WR;
                asel_o   = AS_EXT;
                nxt_st_o = S_F_WR;
            end
        end else if (cur_st == S_DESEL) begin
            kind_o   = K_DESEL;
            asel_o   = AS_NONE;
            nxt_st_o = S_DESEL;
        end else begin
            asel_o   = adv_n ? AS_CUR : AS_NEXT;
            nxt_st_o = is_wr ? S_B_WR : S_B_RD;
            if (adv_n) kind_o = is_wr ? K_SUSP_WR : K_SUSP_RD;
            else       kind_o = is_wr ? K_CONT_WR : K_CONT_RD;
        end
    end
endmodule

// File: rtl/burst_sram_cmd_dec.sv
module burst_sram_cmd_dec
    import bsd_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              adv_n,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [2:0]        kind_o,
    output logic [1:0]        asel_o,
    output logic [LANES-1:0]  lane_we_o,
    output logic [2:0]        state_o,
    output logic [LANES-1:0]  wr_mask_q_o,
    output logic [ADDR_W-1:0] load_addr_q_o
);
    localparam logic [LANES-1:0] NO_LANES = '0;

    typedef struct packed {
        bst_e              st;
        logic [LANES-1:0]  mask;
        logic [ADDR_W-1:0] addr;
    } regs_t;

    regs_t r_d, r_q;

    logic [LANES-1:0] raw_mask;
    logic             is_wr;
    kind_e            kind;
    asel_e            asel;
    bst_e             nxt_st;
    logic [LANES-1:0] lane_we;

    bsd_lane_decode #(.LANES(LANES)) u_lane (
        .gwr_n   (gwr_n),
        .bwr_n   (bwr_n),
        .lane_n  (lane_n),
        .mask_o  (raw_mask),
        .is_wr_o (is_wr)
    );

    bsd_classify u_cls (
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .cpu_stb_n (cpu_stb_n),
        .ctl_stb_n (ctl_stb_n),
        .adv_n     (adv_n),
        .is_wr     (is_wr),
        .cur_st    (r_q.st),
        .kind_o    (kind),
        .asel_o    (asel),
        .nxt_st_o  (nxt_st)
    );

    always_comb begin
        lane_we   = kind_is_write(kind) ? raw_mask : NO_LANES;
        r_d       = r_q;
        r_d.st    = nxt_st;
        r_d.mask  = lane_we;
        if (asel == AS_EXT) r_d.addr = addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_DESEL, mask: '0, addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign kind_o        = kind;
    assign asel_o        = asel;
    assign lane_we_o     = lane_we;
    assign state_o       = r_q.st;
    assign wr_mask_q_o   = r_q.mask;
    assign load_addr_q_o = r_q.addr;

    // R7: a deselect cycle never writes
    a_r7_desel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == 3'd0) |-> (lane_we_o == NO_LANES && asel_o == 2'd0));

    // R8: suspend cycles keep the current address
    a_r8_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == 3'd5 || kind_o == 3'd6) |-> (asel_o == 2'd3));

    // R9: idle strobes in deselect keep the tracker deselected
    a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && ctl_stb_n && (cpu_stb_n || ce1_n)) |=> (state_o == 3'd0));

    // R10: a begin-write opens the first-write state
    a_r10_begin_wr_state: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == 3'd2) |=> (state_o == 3'd2));

    // R11: registered mask matches the lanes sampled at the edge
    a_r11_mask_reg: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_mask_q_o == $past(lane_we_o)));

    // R5: an acting processor strobe never starts a write
    a_r5_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && !ce1_n) |-> (kind_o != 3'd2 && lane_we_o == NO_LANES));
endmodule

// File: tb/burst_sram_cmd_dec_bench.sv
module burst_sram_cmd_dec_bench;
    localparam int LANES  = 4;
    localparam int ADDR_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce1_n, ce2, ce3_n, cpu_stb_n, ctl_stb_n, adv_n, gwr_n, bwr_n;
    logic [LANES-1:0]  lane_n;
    logic [ADDR_W-1:0] addr_i;
    logic [2:0]        kind_o;
    logic [1:0]        asel_o;
    logic [LANES-1:0]  lane_we_o;
    logic [2:0]        state_o;
    logic [LANES-1:0]  wr_mask_q_o;
    logic [ADDR_W-1:0] load_addr_q_o;

    int n_run  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    burst_sram_cmd_dec #(.LANES(LANES), .ADDR_W(ADDR_W)) u_burst_sram_cmd_dec (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
        .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .addr_i(addr_i),
        .kind_o(kind_o), .asel_o(asel_o), .lane_we_o(lane_we_o),
        .state_o(state_o), .wr_mask_q_o(wr_mask_q_o), .load_addr_q_o(load_addr_q_o)
    );

    typedef struct packed {
        logic ce1_n, ce2, ce3_n, cpu_n, ctl_n, adv_n, gw_n, bw_n;
        logic [3:0] lane_n;
        logic [7:0] addr;
        logic [2:0] kind;
        logic [1:0] asel;
        logic [3:0] we;
        logic [2:0] st;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,8'h00,3'd0,2'd0,4'h0,3'd0}, // R9 idle
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,8'h11,3'd1,2'd1,4'h0,3'd1}, // R5 cpu read despite write
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,8'hEE,3'd3,2'd2,4'h0,3'd3}, // R8 continue read
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,8'hEE,3'd6,2'd3,4'hF,3'd4}, // R1 R8 suspend write
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hA,8'h22,3'd2,2'd1,4'h5,3'd2}, // R2 R6 begin write
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,8'hEE,3'd0,2'd0,4'h0,3'd0}, // R7 ce2 low
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,8'h33,3'd1,2'd1,4'h0,3'd1}, // R2 R6 no lane -> read
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,8'hEE,3'd3,2'd2,4'h0,3'd3}, // R4 masked cpu strobe
        '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,8'hEE,3'd0,2'd0,4'h0,3'd0}, // R7 ce1 high
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,8'hEE,3'd0,2'd0,4'h0,3'd0}, // R7 ce3 high
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,8'h44,3'd1,2'd1,4'h0,3'd1}, // R3 bw high
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'h7,8'hEE,3'd4,2'd2,4'h8,3'd4}, // R2 R8 continue write
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,8'hEE,3'd5,2'd3,4'h0,3'd3}, // R8 suspend read
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,8'h55,3'd1,2'd1,4'h0,3'd1}, // R5 cpu beats ctl
        '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,8'hEE,3'd4,2'd2,4'hF,3'd4}  // R1 R8 enables ignored
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; cpu_stb_n = 1'b1; ctl_stb_n = 1'b1;
        adv_n = 1'b1; gwr_n = 1'b1; bwr_n = 1'b1; lane_n = '1; addr_i = '0;
    endtask

    initial begin
        logic [ADDR_W-1:0] mdl_addr;
        mdl_addr = '0;
        idle_inputs();
        #35;
        chk("R12 reset state", 32'(state_o), 32'd0);
        chk("R12 reset mask", 32'(wr_mask_q_o), 32'd0);
        chk("R12 reset addr", 32'(load_addr_q_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ce1_n = TBL[i].ce1_n; ce2 = TBL[i].ce2; ce3_n = TBL[i].ce3_n;
            cpu_stb_n = TBL[i].cpu_n; ctl_stb_n = TBL[i].ctl_n; adv_n = TBL[i].adv_n;
            gwr_n = TBL[i].gw_n; bwr_n = TBL[i].bw_n; lane_n = TBL[i].lane_n;
            addr_i = TBL[i].addr;
            #5;
            chk($sformatf("row %0d kind (R4 R5 R6 R7 R8 R9)", i), 32'(kind_o), 32'(TBL[i].kind));
            chk($sformatf("row %0d asel (R5 R6 R7 R8 R9)", i), 32'(asel_o), 32'(TBL[i].asel));
            chk($sformatf("row %0d lanes (R1 R2 R3)", i), 32'(lane_we_o), 32'(TBL[i].we));
            if (TBL[i].asel == 2'd1) mdl_addr = TBL[i].addr;
            @(posedge clk);
            #1;
            chk($sformatf("row %0d state R10", i), 32'(state_o), 32'(TBL[i].st));
            chk($sformatf("row %0d mask R11", i), 32'(wr_mask_q_o), 32'(TBL[i].we));
            chk($sformatf("row %0d addr R11", i), 32'(load_addr_q_o), 32'(mdl_addr));
        end

        // R12: reset in the middle of an open write burst
        @(negedge clk);
        rst_n = 1'b0;
        #5;
        chk("R12 mid reset state", 32'(state_o), 32'd0);
        chk("R12 mid reset mask", 32'(wr_mask_q_o), 32'd0);
        chk("R12 mid reset addr", 32'(load_addr_q_o), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_inputs();
        adv_n = 1'b0;
        #5;
        chk("R9 idle after reset kind", 32'(kind_o), 32'd0);
        @(posedge clk);
        #1;
        chk("R9 idle after reset state", 32'(state_o), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule